// File: doc/BRIEF.md
# Subclass-1 SYSREF Pulse Generator

This block derives a JESD204B subclass-1 SYSREF timing signal from a fast input clock. One shared counter divides the clock down to a square wave whose period is a whole multiple of a configured local multiframe length. A mode selector decides which periods of that wave reach the outputs. It can pass every period, pass nothing, pass a counted burst of 1, 2, 4 or 8 pulses after a trigger, or pass pulses while a request level stays high. Repeated triggers give a gapped periodic signal.

The gated signal is fanned out to several channels. Each channel delays it by its own number of input-clock cycles so that the SYSREF phase at each converter can be set against its device clock. Gating is only decided at the start of a period, so every pulse that leaves the block has its full width. Changes to the configuration also wait for the next period start.

Top module: `sysref_gen`

## Requirements
- R1: A synchronous active-high reset drives every channel output and `busy` low, including any delay history. The first period starts at the first rising clock edge with reset low.
- R2: The period N equals `cfg_lmfc_len * cfg_mult` cycles, and products below 2 act as 2. In every passed period the common signal is high for the first floor(N/2) cycles and low for the rest.
- R3: With `cfg_mode` = 1 (continuous), every period carries a pulse.
- R4: With `cfg_mode` = 0 (off), all outputs stay low, `trig` is not accepted and `busy` stays low. Switching to burst mode later does not start a burst from that earlier trigger.
- R5: With `cfg_mode` = 2 (burst), a `trig` seen at a clock edge while `busy` is low starts a burst. From the first period start strictly after that edge, exactly 2^`cfg_burst` pulses are passed in consecutive periods: code 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The output then stays low until the next accepted trigger.
- R6: `busy` goes high in the cycle after an accepted trigger. It stays high to the last cycle of the period holding the last burst pulse and is low in the next cycle. A `trig` while `busy` is high is ignored.
- R7: With `cfg_mode` = 3 (request), a period is passed when `req` is high at the clock edge that starts it. A pulse already started when `req` falls completes at full width, and no further pulses follow.
- R8: Changes to `cfg_mode`, `cfg_lmfc_len` and `cfg_mult` take effect at the next period start. The running period keeps its length and gating.
- R9: Channel c drives the common signal delayed by `cfg_dly[c*8 +: 8]` cycles, 0 to 255, independently of the other channels.
- R10: No output ever carries a truncated pulse. Rises happen only at a period start (plus the channel delay), and every high phase lasts floor(N/2) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 0 off, 1 continuous, 2 burst, 3 request |
| cfg_lmfc_len | input | LMFC_W | Multiframe length in clock cycles |
| cfg_mult | input | MULT_W | Multiframes per SYSREF period |
| cfg_burst | input | 2 | Burst length code, pulses = 2^code |
| cfg_dly | input | CH_N*DLY_W | Per-channel delay in cycles, channel 0 in the low bits |
| trig | input | 1 | Burst start request, sampled each edge |
| req | input | 1 | Request-mode level |
| busy | output | 1 | Burst accepted and not yet finished |
| sysref_o | output | CH_N | Delayed SYSREF per channel |

## Verification
The bench builds the block with three channels, a 6-bit multiframe length, a 3-bit multiplier and the full 255-cycle delay depth. Small periods of 2, 4, 5 and 8 cycles make it practical to reach odd periods, the smallest clamped period, a period change in mid-run, every burst length, and triggers that land on a period start. Keeping the full delay depth lets a channel be run at 255 cycles beside channels at 0 and mid-range delays.

// File: rtl/sysref_pkg.sv
package sysref_pkg;

   typedef enum logic [1:0] {
      SR_OFF   = 2'd0,
      SR_CONT  = 2'd1,
      SR_BURST = 2'd2,
      SR_REQ   = 2'd3
   } sr_mode_e;

   localparam int BURST_CODE_W = 2;
   localparam int BURST_LEFT_W = 3;

   function automatic logic [3:0] burst_len(input logic [BURST_CODE_W-1:0] code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/sysref_divider.sv
module sysref_divider #(
   parameter int PER_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PER_W-1:0] per_in,
   output logic             bnd,
   output logic             hi,
   output logic [PER_W-1:0] cnt,
   output logic [PER_W-1:0] half
);

   if (PER_W < 2) begin : g_bad_width
      $error("sysref_divider: PER_W must be at least 2");
   end

   logic             run;
   logic [PER_W-1:0] n_act;

   assign bnd  = !run || (cnt == n_act - PER_W'(1));
   assign half = n_act >> 1;
   assign hi   = run && (cnt < half);

   always_ff @(posedge clk) begin
      if (rst) begin
         run   <= 1'b0;
         cnt   <= '0;
         n_act <= PER_W'(2);
      end else if (bnd) begin
         run   <= 1'b1;
         cnt   <= '0;
         n_act <= per_in;
      end else begin
         cnt   <= cnt + PER_W'(1);
      end
   end

   // R8: the period length only moves at a period start
   a_r8_len_held: assert property (@(posedge clk) disable iff (rst)
      (run && !bnd) |=> $stable(n_act));

   // R2: the count never leaves the current period
   a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt < n_act));

endmodule

// File: rtl/sysref_pulser.sv
module sysref_pulser
   import sysref_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    bnd,
   input  sr_mode_e                mode,
   input  logic [BURST_CODE_W-1:0] burst,
   input  logic                    trig,
   input  logic                    req,
   output logic                    gate,
   output logic                    busy
);

   logic                    armed;
   logic [BURST_LEFT_W-1:0] left;

   always_ff @(posedge clk) begin
      if (rst) begin
         gate  <= 1'b0;
         busy  <= 1'b0;
         armed <= 1'b0;
         left  <= '0;
      end else begin
         if (trig && !busy && mode == SR_BURST) begin
            busy  <= 1'b1;
            armed <= 1'b1;
         end
         if (bnd) begin
            case (mode)
               SR_CONT: begin
                  gate  <= 1'b1;
                  busy  <= 1'b0;
                  armed <= 1'b0;
                  left  <= '0;
               end
               SR_REQ: begin
                  gate  <= req;
                  busy  <= 1'b0;
                  armed <= 1'b0;
                  left  <= '0;
               end
               SR_BURST: begin
                  if (armed) begin
                     gate  <= 1'b1;
                     armed <= 1'b0;
                     left  <= BURST_LEFT_W'(burst_len(burst) - 4'd1);
                  end else if (left != '0) begin
                     gate  <= 1'b1;
                     left  <= left - BURST_LEFT_W'(1);
                  end else begin
                     gate  <= 1'b0;
                     if (busy) busy <= 1'b0;
                  end
               end
               default: begin
                  gate  <= 1'b0;
                  busy  <= 1'b0;
                  armed <= 1'b0;
                  left  <= '0;
               end
            endcase
         end
      end
   end

   // R6: busy can only rise after a trigger
   a_r6_busy_from_trig: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(trig));

   // R10: gating changes only at a period start
   a_r10_gate_at_start: assert property (@(posedge clk) disable iff (rst)
      !bnd |=> $stable(gate));

   // R3: continuous mode passes the next period
   a_r3_cont_passes: assert property (@(posedge clk) disable iff (rst)
      (bnd && mode == SR_CONT) |=> gate);

   // R4: off mode blocks the next period and drops busy
   a_r4_off_blocks: assert property (@(posedge clk) disable iff (rst)
      (bnd && mode == SR_OFF) |=> (!gate && !busy));

   // R7: a low request blocks the next period
   a_r7_req_low_blocks: assert property (@(posedge clk) disable iff (rst)
      (bnd && mode == SR_REQ && !req) |=> !gate);

endmodule

// File: rtl/sysref_dly.sv
module sysref_dly #(
   parameter int MAX_DLY = 255,
   parameter int DLY_W   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             src,
   input  logic [DLY_W-1:0] dly,
   output logic             out
);

   if (MAX_DLY < 1) begin : g_bad_depth
      $error("sysref_dly: MAX_DLY must be at least 1");
   end

   if (MAX_DLY == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
         if (rst) q <= 1'b0;
         else     q <= src;
      end
      assign out = (dly == '0) ? src : q;
   end else begin : g_shift
      logic [MAX_DLY-1:0] sr;
      logic [DLY_W-1:0]   dc;
      always_ff @(posedge clk) begin
         if (rst) sr <= '0;
         else     sr <= {sr[MAX_DLY-2:0], src};
      end
      assign dc  = (dly > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : dly;
      assign out = (dc == '0) ? src : sr[dc - DLY_W'(1)];
   end

   // R9: a one-cycle setting repeats the previous source value
   a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
      ($past(dly) == DLY_W'(1) && dly == DLY_W'(1)) |-> (out == $past(src)));

endmodule

// File: rtl/sysref_gen.sv
module sysref_gen
   import sysref_pkg::*;
#(
   parameter  int CH_N    = 4,
   parameter  int LMFC_W  = 8,
   parameter  int MULT_W  = 4,
   parameter  int MAX_DLY = 255,
   localparam int DLY_W   = $clog2(MAX_DLY + 1),
   localparam int PER_W   = LMFC_W + MULT_W
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [1:0]            cfg_mode,
   input  logic [LMFC_W-1:0]     cfg_lmfc_len,
   input  logic [MULT_W-1:0]     cfg_mult,
   input  logic [1:0]            cfg_burst,
   input  logic [CH_N*DLY_W-1:0] cfg_dly,
   input  logic                  trig,
   input  logic                  req,
   output logic                  busy,
   output logic [CH_N-1:0]       sysref_o
);

   if (CH_N < 1) begin : g_bad_ch
      $error("sysref_gen: CH_N must be at least 1");
   end
   if (LMFC_W < 1 || MULT_W < 1) begin : g_bad_cfg
      $error("sysref_gen: LMFC_W and MULT_W must be at least 1");
   end

   logic [PER_W-1:0] per_raw, per_eff, cnt, half;
   logic             bnd, hi, gate, src;

   assign per_raw = PER_W'(cfg_lmfc_len) * PER_W'(cfg_mult);
   assign per_eff = (per_raw < PER_W'(2)) ? PER_W'(2) : per_raw;

   sysref_divider #(.PER_W(PER_W)) i_div (
      .clk    (clk),
      .rst    (rst),
      .per_in (per_eff),
      .bnd    (bnd),
      .hi     (hi),
      .cnt    (cnt),
      .half   (half)
   );

   sysref_pulser i_pulse (
      .clk   (clk),
      .rst   (rst),
      .bnd   (bnd),
      .mode  (sr_mode_e'(cfg_mode)),
      .burst (cfg_burst),
      .trig  (trig),
      .req   (req),
      .gate  (gate),
      .busy  (busy)
   );

   assign src = gate & hi;

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      sysref_dly #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) i_dly (
         .clk (clk),
         .rst (rst),
         .src (src),
         .dly (cfg_dly[c*DLY_W +: DLY_W]),
         .out (sysref_o[c])
      );
   end

   // R10: the common signal rises only at the first cycle of a period
   a_r10_rise_at_start: assert property (@(posedge clk) disable iff (rst)
      $rose(src) |-> (cnt == '0));

   // R2: the common signal falls only after floor(N/2) cycles
   a_r2_fall_at_half: assert property (@(posedge clk) disable iff (rst)
      $fell(src) |-> (cnt == half));

   // R1: one reset edge clears every output
   a_r1_reset_clears: assert property (@(posedge clk)
      $past(rst) |-> (sysref_o == '0 && !busy));

endmodule

// File: tb/test_sysref_gen.sv
module test_sysref_gen;

   localparam int CH = 3;
   localparam int LW = 6;
   localparam int MW = 3;
   localparam int MD = 255;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    cfg_mode = 2'd0;
   logic [LW-1:0] cfg_lmfc_len = LW'(4);
   logic [MW-1:0] cfg_mult = MW'(1);
   logic [1:0]    cfg_burst = 2'd0;
   logic [CH*DW-1:0] cfg_dly = '0;
   logic          trig = 1'b0;
   logic          req = 1'b0;
   logic          busy;
   logic [CH-1:0] sysref_o;

   always #5 clk = ~clk;

   sysref_gen #(.CH_N(CH), .LMFC_W(LW), .MULT_W(MW), .MAX_DLY(MD)) i_sysref_gen (
      .clk          (clk),
      .rst          (rst),
      .cfg_mode     (cfg_mode),
      .cfg_lmfc_len (cfg_lmfc_len),
      .cfg_mult     (cfg_mult),
      .cfg_burst    (cfg_burst),
      .cfg_dly      (cfg_dly),
      .trig         (trig),
      .req          (req),
      .busy         (busy),
      .sysref_o     (sysref_o)
   );

   // cycle index: 0 after the first edge with reset low
   int k;
   always @(posedge clk) begin
      if (rst) k <= -1;
      else     k <= k + 1;
   end

   int    total = 0;
   int    bad = 0;
   string cur_tag = "R1";
   logic [63:0] expq[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected rise of channel c at cycle t with width w
   task automatic push(input int c, input int t, input int w);
      expq.push_back({16'(c), 16'(w), 32'(t)});
   endtask

   task automatic push_train(input int c, input int first, input int n, input int per,
                             input int w, input int lim);
      for (int m = 0; m < n; m++)
         if (first + m * per <= lim) push(c, first + m * per, w);
   endtask

   // monitor: pops expected rises and checks pulse widths
   bit pv[CH];
   int rk[CH];
   int ew[CH];
   always @(negedge clk) begin
      bit cur;
      int idx;
      if (rst || k < 0) begin
         for (int c = 0; c < CH; c++) pv[c] = 1'b0;
      end else begin
         for (int c = 0; c < CH; c++) begin
            cur = sysref_o[c];
            if (cur && !pv[c]) begin
               idx = -1;
               for (int i = 0; i < expq.size(); i++)
                  if (idx < 0 && expq[i][63:48] == 16'(c)) idx = i;
               if (idx < 0) begin
                  chk(1'b0, {cur_tag, " unexpected rise"}, k, -1);
                  ew[c] = -1;
               end else begin
                  chk(expq[idx][31:0] == 32'(k), {cur_tag, " rise cycle"}, k,
                      int'(expq[idx][31:0]));
                  ew[c] = int'(expq[idx][47:32]);
                  expq.delete(idx);
               end
               rk[c] = k;
            end else if (!cur && pv[c] && ew[c] >= 0) begin
               chk(k - rk[c] == ew[c], {cur_tag, " R10 pulse width"}, k - rk[c], ew[c]);
            end
            pv[c] = cur;
         end
      end
   end

   task automatic start(input int mode, input int lmfc, input int mult, input int bcode,
                        input int d0, input int d1, input int d2, input string tag);
      rst = 1'b1;
      trig = 1'b0;
      req = 1'b0;
      cfg_mode = 2'(mode);
      cfg_lmfc_len = LW'(lmfc);
      cfg_mult = MW'(mult);
      cfg_burst = 2'(bcode);
      cfg_dly = {8'(d2), 8'(d1), 8'(d0)};
      expq.delete();
      repeat (3) @(negedge clk);
      cur_tag = tag;
      rst = 1'b0;
   endtask

   task automatic wait_k(input int j);
      while (k < j) @(negedge clk);
   endtask

   task automatic finish_scn(input int last);
      wait_k(last);
      #1;
      chk(expq.size() == 0, {cur_tag, " missing pulses"}, expq.size(), 0);
   endtask

   task automatic trig_at(input int j);
      wait_k(j - 1);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   initial begin
      int d[3];
      int n, b, j2, b2;

      // R1: outputs low while held in reset
      repeat (4) @(negedge clk);
      chk(sysref_o == '0, "R1 outputs in reset", int'(sysref_o), 0);
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);

      // R3 R9: continuous, N=8, delays 0/3/10
      d = '{0, 3, 10};
      start(1, 4, 2, 0, d[0], d[1], d[2], "R3");
      for (int c = 0; c < CH; c++) push_train(c, d[c], 20, 8, 4, 60);
      finish_scn(60);

      // R2: odd period N=5, high for 2 cycles
      d = '{1, 0, 2};
      start(1, 5, 1, 0, d[0], d[1], d[2], "R2");
      for (int c = 0; c < CH; c++) push_train(c, d[c], 10, 5, 2, 30);
      finish_scn(30);

      // R2: product 1 acts as period 2
      start(1, 1, 1, 0, 0, 0, 0, "R2 clamp");
      for (int c = 0; c < CH; c++) push_train(c, 0, 6, 2, 1, 10);
      finish_scn(10);

      // R8: period change mid-period waits for the next start at 16
      d = '{0, 1, 7};
      start(1, 4, 2, 0, d[0], d[1], d[2], "R8");
      for (int c = 0; c < CH; c++) begin
         push(c, d[c], 4);
         push(c, 8 + d[c], 4);
         push_train(c, 16 + d[c], 10, 4, 2, 40);
      end
      wait_k(13);
      cfg_mult = MW'(1);
      finish_scn(40);

      // R5 R6: every burst length, trigger ignored while busy, retrigger
      for (int cd = 0; cd < 4; cd++) begin
         d = '{0, 2, 5};
         n = 1 << cd;
         b = 8;
         j2 = b + n * 4 + 4;
         b2 = j2 + 4;
         start(2, 4, 1, cd, d[0], d[1], d[2], "R5");
         for (int c = 0; c < CH; c++) begin
            push_train(c, b + d[c], n, 4, 2, 1000);
            push_train(c, b2 + d[c], n, 4, 2, 1000);
         end
         trig_at(6);
         chk(busy == 1'b1, "R6 busy after trigger", int'(busy), 1);
         trig_at(9);
         wait_k(b + n * 4 - 1);
         chk(busy == 1'b1, "R6 busy through last period", int'(busy), 1);
         wait_k(b + n * 4);
         chk(busy == 1'b0, "R6 busy cleared after burst", int'(busy), 0);
         trig_at(j2);
         finish_scn(b2 + n * 4 + 8);
      end

      // R4: off mode ignores trigger, later burst mode stays quiet
      start(0, 4, 1, 1, 0, 0, 0, "R4");
      trig_at(5);
      chk(busy == 1'b0, "R4 busy after trigger in off mode", int'(busy), 0);
      wait_k(10);
      cfg_mode = 2'd2;
      wait_k(25);
      chk(busy == 1'b0, "R4 no burst from earlier trigger", int'(busy), 0);
      finish_scn(30);

      // R7: request held over edges 5..16, passed periods start at 8, 12, 16
      d = '{0, 1, 3};
      start(3, 4, 1, 0, d[0], d[1], d[2], "R7");
      for (int c = 0; c < CH; c++) push_train(c, 8 + d[c], 3, 4, 2, 1000);
      wait_k(4);
      req = 1'b1;
      wait_k(16);
      req = 1'b0;
      finish_scn(40);

      // R9: full 255-cycle delay beside 0 and 128
      d = '{255, 0, 128};
      start(1, 4, 2, 0, d[0], d[1], d[2], "R9");
      for (int c = 0; c < CH; c++) push_train(c, d[c], 40, 8, 4, 300);
      finish_scn(300);

      // R1: reset in the middle of an 8-pulse burst
      d = '{0, 4, 9};
      start(2, 4, 1, 3, d[0], d[1], d[2], "R1");
      for (int c = 0; c < CH; c++) push_train(c, 4 + d[c], 8, 4, 2, 12);
      trig_at(2);
      wait_k(12);
      chk(busy == 1'b1, "R1 busy before mid-burst reset", int'(busy), 1);
      finish_scn(12);
      rst = 1'b1;
      @(negedge clk);
      chk(sysref_o == '0, "R1 outputs after reset", int'(sysref_o), 0);
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule